// File: doc/BRIEF.md
# Two-Thread Back-End Slot Allocator

The block sits between the per-thread micro-operation queues and a shared out-of-order back end. Each cycle it picks at most one of the two threads, accepts that thread's head micro-operation and gives it a reorder slot. A load also gets a load-buffer slot and a store also gets a store-buffer slot. The three pools are shared by the two threads, and each one is split in half. Thread 0 owns the lower half of every pool and thread 1 owns the upper half, so a thread can never take more than its half.

If both threads can make progress, the served thread changes on every clock edge. If one thread is stalled, halted, has no valid work or has filled its half of a pool that it needs, the other thread is served on every cycle with no idle cycles in between. The back end returns slots with single-cycle release pulses, one per pool and thread. Slots are handed out in ring order inside each thread's half. A release may arrive in the same cycle as an allocation.

Top module: `dual_thread_alloc`

## Requirements
- R1: `uop_kind_i` holds two bits per thread (thread t in bits [2t+1:2t]): 0 = other, 1 = load, 2 = store, 3 = treated as other. Every accepted uop takes a reorder slot. Only loads raise `alloc_ldb_valid_o` and only stores raise `alloc_stb_valid_o`.
- R2: Each thread holds at most 63 reorder, 24 load-buffer and 12 store-buffer slots. A uop whose thread has no free slot in a pool it needs is not accepted. The other thread is still served while this is so.
- R3: When both threads are eligible, the served thread is the one not served at the last grant. When both are eligible on consecutive cycles, the served thread changes every cycle.
- R4: A thread with `stall_i` or `halt_i` set is never accepted. The other eligible thread is then served on every cycle.
- R5: At most one uop is accepted per cycle. `uop_ready_o` is high only for the served thread. `alloc_valid_o` equals the OR of the ready bits ANDed with the valids, and `alloc_tid_o` names the served thread.
- R6: Thread t's slot indices lie in [t*C, t*C+C), where C is the per-thread cap of the pool. Each pool hands them out in increasing order starting at t*C and wraps back to t*C after t*C+C-1.
- R7: A release pulse frees one slot of its pool and thread. A release in the same cycle as an allocation leaves the occupancy unchanged. A release on an empty pool is ignored.
- R8: Reset clears all occupancy and ring positions, and thread 0 is preferred first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uop_valid_i | input | 2 | Head uop valid, one bit per thread |
| uop_kind_i | input | 4 | Uop type, two bits per thread |
| uop_ready_o | output | 2 | Uop accepted this cycle, per thread |
| stall_i | input | 2 | Thread stalled, per thread |
| halt_i | input | 2 | Thread halted, per thread |
| rob_rel_i | input | 2 | Free one reorder slot, per thread |
| ldb_rel_i | input | 2 | Free one load-buffer slot, per thread |
| stb_rel_i | input | 2 | Free one store-buffer slot, per thread |
| alloc_valid_o | output | 1 | An allocation happens this cycle |
| alloc_tid_o | output | 1 | Thread that was served |
| alloc_rob_idx_o | output | 7 | Reorder slot index |
| alloc_ldb_valid_o | output | 1 | A load-buffer slot is allocated |
| alloc_ldb_idx_o | output | 6 | Load-buffer slot index |
| alloc_stb_valid_o | output | 1 | A store-buffer slot is allocated |
| alloc_stb_idx_o | output | 5 | Store-buffer slot index |

## Verification
The assertions check the following on every cycle: occupancy never goes above a cap, nothing is taken from a full half, at most one grant is given, consecutive double-eligible cycles alternate, a stalled or halted thread is never accepted, a release with an allocation leaves occupancy unchanged, and a release on an empty pool is ignored. Other behaviour is seen only through the bench's scenarios. These scenarios are the exact number of slots a thread gets before it is refused, the other thread being served past a full thread, the ring order and wrap point of the indices, and the net effect of a release on the next refusal.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int NUM_THREADS = 2;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2,
    KIND_RSVD  = 2'd3
  } uop_kind_e;
endpackage

// File: rtl/ta_pool_slice.sv
// One thread's half of one pool: occupancy plus ring position.
module ta_pool_slice #(
  parameter int CAP  = 63,
  parameter int IDXW = 7,
  parameter int BASE = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            give_i,
  output logic            room_o,
  output logic [IDXW-1:0] idx_o
);
  localparam int CW = $clog2(CAP + 1);
  localparam int TW = $clog2(CAP);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tail_q, tail_d;
  logic          give_eff;

  assign give_eff = give_i && (cnt_q != '0);
  assign room_o   = cnt_q < CW'(CAP);
  assign idx_o    = IDXW'(BASE) + IDXW'(tail_q);

  always_comb begin
    cnt_d  = cnt_q + CW'(take_i) - CW'(give_eff);
    tail_d = tail_q;
    if (take_i) tail_d = (tail_q == TW'(CAP - 1)) ? '0 : tail_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tail_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
    end
  end

  assert_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CAP));
  assert_take_room_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> room_o);
  assert_net_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && give_i && cnt_q != '0) |=> cnt_q == $past(cnt_q));
  assert_empty_rel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && give_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/ta_thread_arb.sv
// Two-way pick; the preference flips to the other thread after each grant.
module ta_thread_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] elig_i,
  output logic [1:0] grant_o
);
  logic pref_q, pref_d;
  logic live_q;

  always_comb begin
    grant_o = elig_i;
    if (elig_i == 2'b11) grant_o = pref_q ? 2'b10 : 2'b01;
    pref_d = pref_q;
    if (grant_o[0]) pref_d = 1'b1;
    else if (grant_o[1]) pref_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pref_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      pref_q <= pref_d;
      live_q <= 1'b1;
    end
  end

  assert_one_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  assert_grant_elig_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~elig_i) == 2'b00);
  assert_alternate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && elig_i == 2'b11 && $past(elig_i) == 2'b11) |-> grant_o != $past(grant_o));
endmodule

// File: rtl/dual_thread_alloc.sv
module dual_thread_alloc
  import alloc_pkg::*;
#(
  parameter  int ROB_DEPTH = 126,
  parameter  int LDB_DEPTH = 48,
  parameter  int STB_DEPTH = 24,
  localparam int ROB_IW    = $clog2(ROB_DEPTH),
  localparam int LDB_IW    = $clog2(LDB_DEPTH),
  localparam int STB_IW    = $clog2(STB_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        uop_valid_i,
  input  logic [3:0]        uop_kind_i,
  output logic [1:0]        uop_ready_o,
  input  logic [1:0]        stall_i,
  input  logic [1:0]        halt_i,
  input  logic [1:0]        rob_rel_i,
  input  logic [1:0]        ldb_rel_i,
  input  logic [1:0]        stb_rel_i,
  output logic              alloc_valid_o,
  output logic              alloc_tid_o,
  output logic [ROB_IW-1:0] alloc_rob_idx_o,
  output logic              alloc_ldb_valid_o,
  output logic [LDB_IW-1:0] alloc_ldb_idx_o,
  output logic              alloc_stb_valid_o,
  output logic [STB_IW-1:0] alloc_stb_idx_o
);
  localparam int ROB_CAP = ROB_DEPTH / NUM_THREADS;
  localparam int LDB_CAP = LDB_DEPTH / NUM_THREADS;
  localparam int STB_CAP = STB_DEPTH / NUM_THREADS;

  logic [1:0] rob_room, ldb_room, stb_room;
  logic [1:0] need_ld, need_st, res_ok, elig, grant;
  logic [ROB_IW-1:0] rob_idx [NUM_THREADS];
  logic [LDB_IW-1:0] ldb_idx [NUM_THREADS];
  logic [STB_IW-1:0] stb_idx [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    uop_kind_e kind;
    assign kind       = uop_kind_e'(uop_kind_i[2*t +: 2]);
    assign need_ld[t] = (kind == KIND_LOAD);
    assign need_st[t] = (kind == KIND_STORE);
    assign res_ok[t]  = rob_room[t] && (!need_ld[t] || ldb_room[t])
                        && (!need_st[t] || stb_room[t]);
    assign elig[t]    = uop_valid_i[t] && !stall_i[t] && !halt_i[t] && res_ok[t];

    ta_pool_slice #(.CAP(ROB_CAP), .IDXW(ROB_IW), .BASE(t * ROB_CAP)) u_rob (
      .clk_i, .rst_ni, .take_i(grant[t]), .give_i(rob_rel_i[t]),
      .room_o(rob_room[t]), .idx_o(rob_idx[t]));
    ta_pool_slice #(.CAP(LDB_CAP), .IDXW(LDB_IW), .BASE(t * LDB_CAP)) u_ldb (
      .clk_i, .rst_ni, .take_i(grant[t] && need_ld[t]), .give_i(ldb_rel_i[t]),
      .room_o(ldb_room[t]), .idx_o(ldb_idx[t]));
    ta_pool_slice #(.CAP(STB_CAP), .IDXW(STB_IW), .BASE(t * STB_CAP)) u_stb (
      .clk_i, .rst_ni, .take_i(grant[t] && need_st[t]), .give_i(stb_rel_i[t]),
      .room_o(stb_room[t]), .idx_o(stb_idx[t]));

    assert_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stall_i[t] || halt_i[t]) |-> !uop_ready_o[t]);
  end

  ta_thread_arb u_arb (.clk_i, .rst_ni, .elig_i(elig), .grant_o(grant));

  assign uop_ready_o       = grant;
  assign alloc_valid_o     = |grant;
  assign alloc_tid_o       = grant[1];
  assign alloc_rob_idx_o   = rob_idx[alloc_tid_o];
  assign alloc_ldb_valid_o = alloc_valid_o && need_ld[alloc_tid_o];
  assign alloc_ldb_idx_o   = ldb_idx[alloc_tid_o];
  assign alloc_stb_valid_o = alloc_valid_o && need_st[alloc_tid_o];
  assign alloc_stb_idx_o   = stb_idx[alloc_tid_o];

  assert_ready_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_ready_o & ~uop_valid_i) == 2'b00);
  assert_kind_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_ldb_valid_o && alloc_stb_valid_o));
  assert_idx_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_o |-> ((alloc_rob_idx_o >= ROB_IW'(ROB_CAP)) == alloc_tid_o));
endmodule

// File: tb/dual_thread_alloc_tb.sv
module dual_thread_alloc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 63, LC = 24, SC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] valid = '0, stall = '0, halt = '0, rrel = '0, lrel = '0, srel = '0;
  logic [3:0] kind = '0;
  logic [1:0] ready;
  logic a_v, a_tid, l_v, s_v;
  logic [6:0] r_idx;
  logic [5:0] l_idx;
  logic [4:0] s_idx;

  int checks = 0, errors = 0, cycles = 0;
  int rob_c[2], ld_c[2], st_c[2], rob_t[2], ld_t[2], st_t[2];
  int pref = 0, served = -1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_thread_alloc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .uop_valid_i(valid), .uop_kind_i(kind),
    .uop_ready_o(ready), .stall_i(stall), .halt_i(halt), .rob_rel_i(rrel),
    .ldb_rel_i(lrel), .stb_rel_i(srel), .alloc_valid_o(a_v), .alloc_tid_o(a_tid),
    .alloc_rob_idx_o(r_idx), .alloc_ldb_valid_o(l_v), .alloc_ldb_idx_o(l_idx),
    .alloc_stb_valid_o(s_v), .alloc_stb_idx_o(s_idx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin
      rob_c[t] = 0; ld_c[t] = 0; st_c[t] = 0;
      rob_t[t] = 0; ld_t[t] = 0; st_t[t] = 0;
    end
    pref = 0;
  endtask

  // Drive one cycle at the falling edge, compare, then advance the model.
  task automatic step(input logic [1:0] v, input logic [3:0] k, input logic [1:0] st,
                      input logic [1:0] hl, input logic [1:0] rr, input logic [1:0] lr,
                      input logic [1:0] sr);
    bit el[2], nl[2], ns[2];
    int exp_ready;
    @(negedge clk);
    valid = v; kind = k; stall = st; halt = hl; rrel = rr; lrel = lr; srel = sr;
    #1;
    for (int t = 0; t < 2; t++) begin
      nl[t] = (k[2*t +: 2] == 2'd1);
      ns[t] = (k[2*t +: 2] == 2'd2);
      el[t] = v[t] && !st[t] && !hl[t] && rob_c[t] < RC
              && (!nl[t] || ld_c[t] < LC) && (!ns[t] || st_c[t] < SC);
    end
    if (el[0] && el[1]) served = pref;
    else if (el[0]) served = 0;
    else if (el[1]) served = 1;
    else served = -1;
    exp_ready = (served < 0) ? 0 : (1 << served);
    chk(ready == exp_ready, "R5 ready", ready, exp_ready);
    chk(a_v == (served >= 0), "R5 alloc_valid", a_v, served >= 0);
    if (served >= 0) begin
      chk(a_tid == served, "R3/R4 tid", a_tid, served);
      chk(r_idx == served * RC + rob_t[served], "R6 rob idx", r_idx, served * RC + rob_t[served]);
      chk(l_v == nl[served], "R1 ldb valid", l_v, nl[served]);
      chk(s_v == ns[served], "R1 stb valid", s_v, ns[served]);
      if (nl[served]) chk(l_idx == served * LC + ld_t[served], "R6 ldb idx", l_idx, served * LC + ld_t[served]);
      if (ns[served]) chk(s_idx == served * SC + st_t[served], "R6 stb idx", s_idx, served * SC + st_t[served]);
    end
    for (int t = 0; t < 2; t++) begin
      if (rr[t] && rob_c[t] > 0) rob_c[t]--;
      if (lr[t] && ld_c[t] > 0) ld_c[t]--;
      if (sr[t] && st_c[t] > 0) st_c[t]--;
    end
    if (served >= 0) begin
      rob_c[served]++; rob_t[served] = (rob_t[served] + 1) % RC;
      if (nl[served]) begin ld_c[served]++; ld_t[served] = (ld_t[served] + 1) % LC; end
      if (ns[served]) begin st_c[served]++; st_t[served] = (st_t[served] + 1) % SC; end
      pref = 1 - served;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int acc, prev;
    void'($urandom(32'h5eed1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(a_v == 1'b0 && ready == 2'b00, "R8 idle in reset", {a_v, ready}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R8: first contested grant goes to thread 0
    step(2'b11, 4'b0000, 0, 0, 0, 0, 0);
    chk(served == 0, "R8 first pick", served, 0);
    chk(r_idx == 0, "R8 rob ring start", r_idx, 0);

    // R3: alternation under constant contention
    prev = served;
    for (int i = 0; i < 6; i++) begin
      step(2'b11, 4'b0000, 0, 0, 0, 0, 0);
      chk(served == 1 - prev, "R3 alternate", served, 1 - prev);
      prev = served;
    end

    // R4: stalled / halted thread yields every cycle to the other
    for (int i = 0; i < 4; i++) begin
      step(2'b11, 4'b0000, 2'b01, 0, 0, 0, 0);
      chk(served == 1, "R4 stall t0", served, 1);
    end
    for (int i = 0; i < 4; i++) begin
      step(2'b11, 4'b0000, 0, 2'b10, 0, 0, 0);
      chk(served == 0, "R4 halt t1", served, 0);
    end

    // R2: store cap of thread 0
    acc = 0;
    for (int i = 0; i < 14; i++) begin
      step(2'b01, 4'b0010, 0, 0, 0, 0, 0);
      if (served == 0) acc++;
    end
    chk(acc == SC, "R2 store cap", acc, SC);
    step(2'b11, 4'b1010, 0, 0, 0, 0, 0);
    chk(served == 1, "R2 other thread served past full", served, 1);

    // R7: release with allocation attempt while full, then net effect
    step(2'b01, 4'b0010, 0, 0, 0, 0, 2'b01);
    chk(served == -1, "R7 full during release cycle", served, -1);
    acc = 0;
    for (int i = 0; i < 3; i++) begin
      step(2'b01, 4'b0010, 0, 0, 0, 0, 0);
      if (served == 0) acc++;
    end
    chk(acc == 1, "R7 one slot freed", acc, 1);

    // R7: releases on empty load half are ignored
    for (int i = 0; i < 3; i++) step(2'b00, 4'b0000, 0, 0, 0, 2'b10, 0);
    acc = 0;
    for (int i = 0; i < 26; i++) begin
      step(2'b10, 4'b0100, 0, 0, 0, 0, 0);
      if (served == 1) acc++;
    end
    chk(acc == LC, "R7 empty release ignored", acc, LC);

    // R1: kind 3 behaves as other
    step(2'b01, 4'b0011, 0, 0, 2'b01, 0, 0);
    chk(served == 0 && l_v == 0 && s_v == 0, "R1 kind 3", {l_v, s_v}, 0);

    // Random phase: ring wrap (R6), caps (R2), netting (R7)
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] v, st, hl, rr, lr, sr;
      logic [3:0] k;
      v  = 2'($urandom_range(3));
      k  = 4'($urandom_range(15));
      st = ($urandom_range(9) == 0) ? 2'($urandom_range(3)) : 2'b00;
      hl = ($urandom_range(19) == 0) ? 2'($urandom_range(3)) : 2'b00;
      rr = {($urandom_range(2) == 0), ($urandom_range(2) == 0)};
      lr = {($urandom_range(2) == 0), ($urandom_range(2) == 0)};
      sr = {($urandom_range(2) == 0), ($urandom_range(2) == 0)};
      step(v, k, st, hl, rr, lr, sr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule